// File: doc/BRIEF.md
# Interrupt History Log

This block keeps a wrapping record of the sixteen most recent host interrupt events and drives two active-low interrupt request pins. Any number of event sources may present an identification word (one bit per interrupt type) and an address word (pointing at related message data) in a cycle. Sources that present in the same cycle are folded into a single record. Each record takes two consecutive words of a small log store: the identification word at the even word and the address word at the odd word after it.

A host-visible pointer gives the word position where the next record will land. The host reads any word of the store through a combinational read port. The upper field of the identification word holds the hardware/status types, which drive the hardware pin. The lower field holds the message types, which drive the message pin.

One configuration bit selects how both pins signal. They can give a fixed four-cycle low pulse, or a low level that holds until the host acknowledges that pin. A second configuration bit turns recording off. The pins keep working while recording is off.

Top module: `irq_hist_log`

## Requirements
- R1: After reset, `log_ptr` is 0, both interrupt pins are high, and every word of the log store reads 0.
- R2: An accepted event writes its identification word to word `log_ptr` and its address word to word `log_ptr+1`, then advances `log_ptr` by 2. `log_ptr` is always even.
- R3: With 16 entries, `log_ptr` wraps from 30 back to 0. The seventeenth record after a wrap overwrites entry 0, which is words 0 and 1.
- R4: When several sources are valid in one cycle, they form one record. Its identification word is the bitwise OR of their identification words. Its address word comes from the lowest-numbered valid source.
- R5: While `cfg_log_en` is 0, events change neither the store nor `log_ptr`, but they still drive the interrupt pins.
- R6: An event whose merged identification word has any bit set in bits 15..8 drives `irq_hw_n` low. An event with any bit set in bits 7..0 drives `irq_msg_n` low. Both pins respond from the cycle after the event.
- R7: With `cfg_level_mode` = 0, a pin goes low for exactly 4 clock cycles, starting in the cycle after the event.
- R8: With `cfg_level_mode` = 1, a pin stays low until its own acknowledge input is high for a cycle. It goes high in the cycle after that acknowledge. The other pin's acknowledge has no effect on it.
- R9: In pulse mode, a new event for a pin that is already pulsing restarts the 4-cycle window.
- R10: In level mode, an event and an acknowledge for the same pin in the same cycle leave the pin low.
- R11: A valid event whose merged identification word is zero is ignored. Nothing is recorded, the pointer does not move, and no pin is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_log_en | input | 1 | Enables recording of events |
| cfg_level_mode | input | 1 | 1: level mode on both pins; 0: pulse mode |
| ev_vld | input | N_SRC | Per-source event valid |
| ev_id | input | N_SRC*DATA_W | Per-source identification words, source 0 in the low bits |
| ev_addr | input | N_SRC*DATA_W | Per-source address words, source 0 in the low bits |
| ack_hw | input | 1 | Host acknowledge for the hardware pin |
| ack_msg | input | 1 | Host acknowledge for the message pin |
| rd_word | input | $clog2(2*DEPTH) | Word index for a host read of the store |
| rd_data | output | DATA_W | Word read from the store |
| log_ptr | output | $clog2(2*DEPTH) | Word position of the next record |
| irq_hw_n | output | 1 | Hardware/status interrupt, active low |
| irq_msg_n | output | 1 | Message interrupt, active low |

## Verification
The bench drives several event patterns, and each one separates a different fault:
- A single hardware-only event shows that the pins are routed by field.
- Two sources in one cycle, carrying disjoint type bits and different addresses, show OR merging and the priority given to the lower-numbered source for the address.
- A valid event with an all-zero identification word, and an event sent while recording is off, show that recording is gated separately from the pins.
- A run of distinct events that takes the pointer through zero shows the wrap and the overwrite of entry 0.

Pulse and level modes are each timed cycle by cycle. The timing runs cover a retrigger during a pulse, an acknowledge on the wrong pin, and an acknowledge that lands in the same cycle as a new event.

// File: rtl/irq_log_pkg.sv
package irq_log_pkg;
   localparam int N_PINS = 2;
   typedef enum logic [0:0] {
      PIN_HW  = 1'b0,
      PIN_MSG = 1'b1
   } irq_pin_e;
endpackage

// File: rtl/irq_src_merge.sv
module irq_src_merge #(
   parameter int N_SRC  = 2,
   parameter int DATA_W = 16
) (
   input  logic [N_SRC-1:0]        src_vld,
   input  logic [N_SRC*DATA_W-1:0] src_id,
   input  logic [N_SRC*DATA_W-1:0] src_addr,
   output logic                    mrg_vld,
   output logic [DATA_W-1:0]       mrg_id,
   output logic [DATA_W-1:0]       mrg_addr
);
   logic [DATA_W-1:0] id_gated [N_SRC];

   for (genvar g = 0; g < N_SRC; g++) begin : g_gate
      assign id_gated[g] = src_vld[g] ? src_id[g*DATA_W +: DATA_W] : '0;
   end

   always_comb begin
      mrg_id   = '0;
      mrg_addr = '0;
      for (int i = 0; i < N_SRC; i++) begin
         mrg_id = mrg_id | id_gated[i];
      end
      for (int i = N_SRC-1; i >= 0; i--) begin
         if (src_vld[i]) begin
            mrg_addr = src_addr[i*DATA_W +: DATA_W];
         end
      end
   end

   assign mrg_vld = (|src_vld) && (mrg_id != '0);
endmodule

// File: rtl/irq_log_store.sv
module irq_log_store #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 16,
   localparam int ENT_W  = $clog2(DEPTH),
   localparam int WORD_W = ENT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_id,
   input  logic [DATA_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] rd_word,
   output logic [DATA_W-1:0] rd_data,
   output logic [WORD_W-1:0] ptr_word
);
   logic [DATA_W-1:0] id_mem  [DEPTH];
   logic [DATA_W-1:0] adr_mem [DEPTH];
   logic [ENT_W-1:0]  wr_ent;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ent <= '0;
      end else if (wr_en) begin
         wr_ent <= wr_ent + 1'b1;
      end
   end

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            id_mem[e]  <= '0;
            adr_mem[e] <= '0;
         end else if (wr_en && (wr_ent == ENT_W'(e))) begin
            id_mem[e]  <= wr_id;
            adr_mem[e] <= wr_addr;
         end
      end
   end

   assign ptr_word = {wr_ent, 1'b0};
   assign rd_data  = rd_word[0] ? adr_mem[rd_word[WORD_W-1:1]]
                                : id_mem[rd_word[WORD_W-1:1]];
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv #(
   parameter int PULSE_LEN = 4,
   localparam int CNT_W = $clog2(PULSE_LEN + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level_mode,
   input  logic fire,
   input  logic ack,
   output logic pin_n
);
   logic             held;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held <= 1'b0;
         cnt  <= '0;
      end else begin
         if (fire && level_mode) begin
            held <= 1'b1;
         end else if (ack) begin
            held <= 1'b0;
         end
         if (fire && !level_mode) begin
            cnt <= CNT_W'(PULSE_LEN);
         end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   assign pin_n = level_mode ? ~held : (cnt == '0);
endmodule

// File: rtl/irq_hist_log.sv
module irq_hist_log
   import irq_log_pkg::*;
#(
   parameter int N_SRC     = 2,
   parameter int DATA_W    = 16,
   parameter int MSG_BITS  = 8,
   parameter int DEPTH     = 16,
   parameter int PULSE_LEN = 4,
   localparam int WORD_W   = $clog2(2*DEPTH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_log_en,
   input  logic                    cfg_level_mode,
   input  logic [N_SRC-1:0]        ev_vld,
   input  logic [N_SRC*DATA_W-1:0] ev_id,
   input  logic [N_SRC*DATA_W-1:0] ev_addr,
   input  logic                    ack_hw,
   input  logic                    ack_msg,
   input  logic [WORD_W-1:0]       rd_word,
   output logic [DATA_W-1:0]       rd_data,
   output logic [WORD_W-1:0]       log_ptr,
   output logic                    irq_hw_n,
   output logic                    irq_msg_n
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("irq_hist_log: DEPTH must be a power of two of at least 2");
   end
   if (MSG_BITS < 1 || MSG_BITS >= DATA_W) begin : g_bad_split
      $error("irq_hist_log: MSG_BITS must leave at least one hardware bit");
   end
   if (N_SRC < 1 || PULSE_LEN < 1) begin : g_bad_cnt
      $error("irq_hist_log: N_SRC and PULSE_LEN must be positive");
   end

   logic              mrg_vld;
   logic [DATA_W-1:0] mrg_id;
   logic [DATA_W-1:0] mrg_addr;
   logic [N_PINS-1:0] pin_fire;
   logic [N_PINS-1:0] pin_ack;
   logic [N_PINS-1:0] pin_n;

   irq_src_merge #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_merge (
      .src_vld  (ev_vld),
      .src_id   (ev_id),
      .src_addr (ev_addr),
      .mrg_vld  (mrg_vld),
      .mrg_id   (mrg_id),
      .mrg_addr (mrg_addr)
   );

   irq_log_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (mrg_vld && cfg_log_en),
      .wr_id    (mrg_id),
      .wr_addr  (mrg_addr),
      .rd_word  (rd_word),
      .rd_data  (rd_data),
      .ptr_word (log_ptr)
   );

   assign pin_fire[PIN_HW]  = mrg_vld && (|mrg_id[DATA_W-1:MSG_BITS]);
   assign pin_fire[PIN_MSG] = mrg_vld && (|mrg_id[MSG_BITS-1:0]);
   assign pin_ack[PIN_HW]   = ack_hw;
   assign pin_ack[PIN_MSG]  = ack_msg;

   for (genvar p = 0; p < N_PINS; p++) begin : g_pin
      irq_pin_drv #(.PULSE_LEN(PULSE_LEN)) u_drv (
         .clk        (clk),
         .rst_n      (rst_n),
         .level_mode (cfg_level_mode),
         .fire       (pin_fire[p]),
         .ack        (pin_ack[p]),
         .pin_n      (pin_n[p])
      );
   end

   assign irq_hw_n  = pin_n[PIN_HW];
   assign irq_msg_n = pin_n[PIN_MSG];
endmodule

// File: rtl/irq_hist_log_chk.sv
module irq_hist_log_chk #(
   parameter int N_SRC    = 2,
   parameter int DATA_W   = 16,
   parameter int MSG_BITS = 8,
   parameter int WORD_W   = 5
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    cfg_log_en,
   input logic                    cfg_level_mode,
   input logic [N_SRC-1:0]        ev_vld,
   input logic [N_SRC*DATA_W-1:0] ev_id,
   input logic                    ack_hw,
   input logic                    ack_msg,
   input logic [WORD_W-1:0]       log_ptr,
   input logic                    irq_hw_n,
   input logic                    irq_msg_n
);
   logic [DATA_W-1:0] any_id;
   always_comb begin
      any_id = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (ev_vld[i]) any_id = any_id | ev_id[i*DATA_W +: DATA_W];
      end
   end

   // R2: pointer stays on an even word
   a_r2_ptr_even: assert property (@(posedge clk) disable iff (!rst_n)
      log_ptr[0] == 1'b0);

   // R2, R3: one accepted record moves the pointer by two words (modulo the store)
   a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_log_en && any_id != '0) |=> log_ptr == WORD_W'($past(log_ptr) + 2));

   // R5, R11: disabled recording or an empty event leaves the pointer alone
   a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_log_en || any_id == '0) |=> $stable(log_ptr));

   // R6: hardware field drives the hardware pin low next cycle
   a_r6_hw_fire: assert property (@(posedge clk) disable iff (!rst_n)
      (|any_id[DATA_W-1:MSG_BITS]) |=>
         (cfg_level_mode != $past(cfg_level_mode)) || !irq_hw_n);

   // R8: in level mode the message pin holds until its own acknowledge
   a_r8_msg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_level_mode && !irq_msg_n && !ack_msg) |=>
         (!cfg_level_mode || !irq_msg_n));
endmodule

bind irq_hist_log irq_hist_log_chk #(
   .N_SRC(N_SRC), .DATA_W(DATA_W), .MSG_BITS(MSG_BITS), .WORD_W(WORD_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cfg_log_en     (cfg_log_en),
   .cfg_level_mode (cfg_level_mode),
   .ev_vld         (ev_vld),
   .ev_id          (ev_id),
   .ack_hw         (ack_hw),
   .ack_msg        (ack_msg),
   .log_ptr        (log_ptr),
   .irq_hw_n       (irq_hw_n),
   .irq_msg_n      (irq_msg_n)
);

// File: tb/sim_irq_hist_log.sv
`timescale 1ns/1ps
module sim_irq_hist_log;
   localparam int N_SRC = 2;
   localparam int DW    = 16;
   localparam int WW    = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_log_en = 1'b1;
   logic            cfg_level_mode = 1'b0;
   logic [N_SRC-1:0] ev_vld = '0;
   logic [N_SRC*DW-1:0] ev_id = '0;
   logic [N_SRC*DW-1:0] ev_addr = '0;
   logic            ack_hw = 1'b0;
   logic            ack_msg = 1'b0;
   logic [WW-1:0]   rd_word = '0;
   logic [DW-1:0]   rd_data;
   logic [WW-1:0]   log_ptr;
   logic            irq_hw_n;
   logic            irq_msg_n;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   irq_hist_log u0 (
      .clk(clk), .rst_n(rst_n), .cfg_log_en(cfg_log_en),
      .cfg_level_mode(cfg_level_mode), .ev_vld(ev_vld), .ev_id(ev_id),
      .ev_addr(ev_addr), .ack_hw(ack_hw), .ack_msg(ack_msg),
      .rd_word(rd_word), .rd_data(rd_data), .log_ptr(log_ptr),
      .irq_hw_n(irq_hw_n), .irq_msg_n(irq_msg_n)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [WW-1:0] w, output logic [DW-1:0] d);
      rd_word = w;
      #1 d = rd_data;
   endtask

   // drive one cycle of events; returns at the falling edge after the capture edge
   task automatic ev(input logic [1:0] v, input logic [DW-1:0] i0, input logic [DW-1:0] a0,
                     input logic [DW-1:0] i1, input logic [DW-1:0] a1);
      @(negedge clk);
      ev_vld = v; ev_id = {i1, i0}; ev_addr = {a1, a0};
      @(negedge clk);
      ev_vld = '0; ev_id = '0; ev_addr = '0;
   endtask

   task automatic t_reset;
      logic [DW-1:0] d;
      check("R1 ptr", 32'(log_ptr), 0);
      check("R1 hw pin", 32'(irq_hw_n), 1);
      check("R1 msg pin", 32'(irq_msg_n), 1);
      rd(0, d);  check("R1 word0", 32'(d), 0);
      rd(31, d); check("R1 word31", 32'(d), 0);
   endtask

   task automatic t_single_pulse;
      logic [DW-1:0] d;
      ev(2'b01, 16'h0100, 16'hA000, 16'h0, 16'h0);
      check("R2 ptr", 32'(log_ptr), 2);
      rd(0, d); check("R2 id word", 32'(d), 32'h0100);
      rd(1, d); check("R2 addr word", 32'(d), 32'hA000);
      check("R6 hw low", 32'(irq_hw_n), 0);
      check("R6 msg high", 32'(irq_msg_n), 1);
      for (int k = 2; k <= 4; k++) begin
         @(negedge clk);
         check("R7 pulse low", 32'(irq_hw_n), 0);
      end
      @(negedge clk);
      check("R7 pulse ended", 32'(irq_hw_n), 1);
   endtask

   task automatic t_merge;
      logic [DW-1:0] d;
      ev(2'b11, 16'h0001, 16'h1111, 16'h0200, 16'h2222);
      check("R4 ptr one entry", 32'(log_ptr), 4);
      rd(2, d); check("R4 or id", 32'(d), 32'h0201);
      rd(3, d); check("R4 low src addr", 32'(d), 32'h1111);
      check("R6 both hw", 32'(irq_hw_n), 0);
      check("R6 both msg", 32'(irq_msg_n), 0);
      ev(2'b10, 16'h0, 16'h0, 16'h0004, 16'h3333);
      rd(5, d); check("R4 src1 addr", 32'(d), 32'h3333);
      repeat (6) @(negedge clk);
   endtask

   task automatic t_zero_id;
      ev(2'b01, 16'h0000, 16'h5555, 16'h0, 16'h0);
      check("R11 ptr held", 32'(log_ptr), 6);
      check("R11 hw high", 32'(irq_hw_n), 1);
      check("R11 msg high", 32'(irq_msg_n), 1);
   endtask

   task automatic t_disable;
      logic [DW-1:0] d;
      cfg_log_en = 1'b0;
      ev(2'b01, 16'h0010, 16'h7777, 16'h0, 16'h0);
      check("R5 ptr held", 32'(log_ptr), 6);
      check("R5 pin still fires", 32'(irq_msg_n), 0);
      rd(6, d); check("R5 slot untouched", 32'(d), 0);
      rd(7, d); check("R5 slot addr untouched", 32'(d), 0);
      cfg_log_en = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic t_wrap;
      logic [DW-1:0] d;
      int n;
      n = (32 - int'(log_ptr)) / 2;
      for (int k = 0; k < n; k++) begin
         ev(2'b01, 16'h0040 + 16'(k), 16'hC000 + 16'(k), 16'h0, 16'h0);
      end
      check("R3 wrapped ptr", 32'(log_ptr), 0);
      rd(30, d); check("R3 last entry", 32'(d), 32'(16'h0040 + 16'(n-1)));
      ev(2'b01, 16'hBE00, 16'hBEEF, 16'h0, 16'h0);
      rd(0, d); check("R3 entry0 id overwritten", 32'(d), 32'hBE00);
      rd(1, d); check("R3 entry0 addr overwritten", 32'(d), 32'hBEEF);
      check("R3 ptr after", 32'(log_ptr), 2);
      repeat (6) @(negedge clk);
   endtask

   task automatic t_retrigger;
      ev(2'b01, 16'h0002, 16'h0, 16'h0, 16'h0);
      @(negedge clk);
      ev(2'b01, 16'h0002, 16'h0, 16'h0, 16'h0);
      for (int k = 2; k <= 4; k++) begin
         @(negedge clk);
         check("R9 restarted low", 32'(irq_msg_n), 0);
      end
      @(negedge clk);
      check("R9 restarted end", 32'(irq_msg_n), 1);
   endtask

   task automatic t_level;
      cfg_level_mode = 1'b1;
      ev(2'b01, 16'h0008, 16'h0, 16'h0, 16'h0);
      repeat (8) @(negedge clk);
      check("R8 held low", 32'(irq_msg_n), 0);
      ack_hw = 1'b1; @(negedge clk); ack_hw = 1'b0;
      check("R8 other ack ignored", 32'(irq_msg_n), 0);
      ack_msg = 1'b1; @(negedge clk); ack_msg = 1'b0;
      check("R8 released", 32'(irq_msg_n), 1);
      ev(2'b01, 16'h0800, 16'h0, 16'h0, 16'h0);
      check("R8 hw level low", 32'(irq_hw_n), 0);
      @(negedge clk);
      ev_vld = 2'b01; ev_id = {16'h0, 16'h0800}; ack_hw = 1'b1;
      @(negedge clk);
      ev_vld = '0; ev_id = '0; ack_hw = 1'b0;
      check("R10 set wins", 32'(irq_hw_n), 0);
      ack_hw = 1'b1; @(negedge clk); ack_hw = 1'b0;
      check("R10 later ack clears", 32'(irq_hw_n), 1);
      cfg_level_mode = 1'b0;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single_pulse();
      t_merge();
      t_zero_id();
      t_disable();
      t_wrap();
      t_retrigger();
      t_level();
      finish_run();
   end

   initial begin
      #(200000 * 20);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule